// File: doc/BRIEF.md
# Per-Address Two-Bit Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It holds a table of two-bit state counters. A few low-order bits of the branch PC pick one counter. The word-alignment bits below them and every bit above them are ignored, so branches that share those index bits share a counter. A lookup is purely combinational: the front end presents a PC and receives a taken or not-taken guess in the same cycle. The guess is the upper bit of the selected counter.

Once the branch resolves, the back end presents its PC and its real direction on the update port. The selected counter then moves to its next state on the following clock edge. The counter does not count up and down one step at a time. A not-taken outcome from any state other than strongly-taken drops the counter to strongly-not-taken. A taken outcome from either weak state jumps to strongly-taken.

A synchronous active-low reset loads every counter with a state fixed by a parameter. The table depth, PC width and number of alignment bits are also parameters.

Top module: `dir_predictor`

## Requirements
- R1: While rst_n is low at a clock edge, every counter is loaded with INIT_STATE (default 2'b10). After reset with the default value, a lookup of any PC returns taken.
- R2: The entry index is pc[ALIGN_BITS +: log2(DEPTH)], with ALIGN_BITS = 2 by default. PC bits outside that field have no effect on which counter is read or written.
- R3: lkp_taken equals bit 1 of the counter selected by lkp_pc, in the same cycle, with no clock edge in between (1 = taken).
- R4: A counter at 2'b00 moves to 2'b01 on a taken update and stays at 2'b00 on a not-taken update.
- R5: A counter at 2'b01 moves to 2'b11 on a taken update and to 2'b00 on a not-taken update.
- R6: A counter at 2'b10 moves to 2'b11 on a taken update and to 2'b00 on a not-taken update.
- R7: A counter at 2'b11 stays at 2'b11 on a taken update and moves to 2'b10 on a not-taken update.
- R8: An update changes only the counter its PC selects; every other counter keeps its state.
- R9: When upd_en is low, no counter changes, whatever upd_pc and upd_taken are.
- R10: When a lookup and an update select the same counter in one cycle, lkp_taken shows the state before the update. The new state is visible from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| lkp_pc | input | PC_W | PC of the branch being predicted |
| lkp_taken | output | 1 | Prediction for lkp_pc: 1 taken, 0 not taken |
| upd_en | input | 1 | Applies a resolved outcome at this clock edge |
| upd_pc | input | PC_W | PC of the resolved branch |
| upd_taken | input | 1 | Actual direction of the resolved branch: 1 taken |

## Verification
Only one bit of each counter reaches the ports, so an error in the lower bit stays hidden until a later outcome moves that counter. For example, a wrong step out of a weak state only shows up as a wrong prediction after the next update that hits the same entry. That takes at least one more update and one lookup, two cycles at the earliest. The bench therefore keeps running outcome sequences on each entry so that hidden state errors reach the prediction bit. It also reads back an entry on the cycle after it was written. It re-reads the whole table at intervals to catch writes that strayed into a neighbouring entry.

// File: rtl/bp2_pkg.sv
// Shared definitions for the two-bit branch predictor.
// Assumes a counter is two bits wide and its upper bit is the prediction.
package bp2_pkg;
    typedef logic [1:0] ctr_t;
    localparam ctr_t CTR_STRONG_NT = 2'b00;
    localparam ctr_t CTR_WEAK_NT   = 2'b01;
    localparam ctr_t CTR_WEAK_T    = 2'b10;
    localparam ctr_t CTR_STRONG_T  = 2'b11;
endpackage

// File: rtl/bp2_index.sv
// Extracts the table index from a branch PC.
// Assumes word-aligned PCs: ALIGN_BITS low bits are dropped, bits above the field are ignored.
module bp2_index #(
    parameter int PC_W       = 32,
    parameter int DEPTH      = 16,
    parameter int ALIGN_BITS = 2,
    localparam int IDX_W     = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic [PC_W-1:0]  pc,
    output logic [IDX_W-1:0] idx
);
    // Select the index field just above the alignment bits.
    assign idx = pc[ALIGN_BITS +: IDX_W];

    // R2: the index equals the word address reduced modulo the table depth.
    always_comb begin
        a_r2_index_slice: assert ((pc >> ALIGN_BITS) % PC_W'(DEPTH) == PC_W'(idx));
    end
endmodule

// File: rtl/bp2_ctr_next.sv
// Next-state function of one two-bit counter.
// Not-taken from any state below strongly-taken clears to 00; taken from a weak state jumps to 11.
module bp2_ctr_next
    import bp2_pkg::*;
(
    input  ctr_t cur,
    input  logic taken,
    output ctr_t nxt
);
    // Compute the successor state from the current state and the outcome.
    always_comb begin
        unique case (cur)
            CTR_STRONG_NT: nxt = taken ? CTR_WEAK_NT  : CTR_STRONG_NT;
            CTR_WEAK_NT:   nxt = taken ? CTR_STRONG_T : CTR_STRONG_NT;
            CTR_WEAK_T:    nxt = taken ? CTR_STRONG_T : CTR_STRONG_NT;
            default:       nxt = taken ? CTR_STRONG_T : CTR_WEAK_T;
        endcase
    end
endmodule

// File: rtl/bp2_entry.sv
// One counter of the table.
// Assumes the caller raises we only for the single entry the update selects.
module bp2_entry
    import bp2_pkg::*;
#(
    parameter ctr_t INIT_STATE = CTR_WEAK_T
) (
    input  logic clk,
    input  logic rst_n,
    input  logic we,
    input  logic taken,
    input  ctr_t nxt,
    output ctr_t q
);
    // Hold the counter state, load the initial state on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)  q <= INIT_STATE;
        else if (we) q <= nxt;
    end

    a_r1_reset_init: assert property (@(posedge clk) !rst_n |=> q == INIT_STATE);
    a_r4_from_00: assert property (@(posedge clk) disable iff (!rst_n)
        (we && q == 2'b00) |=> q == (($past(taken)) ? 2'b01 : 2'b00));
    a_r5_from_01: assert property (@(posedge clk) disable iff (!rst_n)
        (we && q == 2'b01) |=> q == (($past(taken)) ? 2'b11 : 2'b00));
    a_r6_from_10: assert property (@(posedge clk) disable iff (!rst_n)
        (we && q == 2'b10) |=> q == (($past(taken)) ? 2'b11 : 2'b00));
    a_r7_from_11: assert property (@(posedge clk) disable iff (!rst_n)
        (we && q == 2'b11) |=> q == (($past(taken)) ? 2'b11 : 2'b10));
    a_r8_hold_unselected: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(q));
endmodule

// File: rtl/dir_predictor.sv
// Per-address two-bit branch direction predictor.
// Lookup is combinational; an update writes the selected counter at the next clock edge.
// Assumes DEPTH is a power of two.
module dir_predictor
    import bp2_pkg::*;
#(
    parameter int   PC_W       = 32,
    parameter int   DEPTH      = 16,
    parameter int   ALIGN_BITS = 2,
    parameter ctr_t INIT_STATE = CTR_WEAK_T
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] lkp_pc,
    output logic            lkp_taken,
    input  logic            upd_en,
    input  logic [PC_W-1:0] upd_pc,
    input  logic            upd_taken
);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [IDX_W-1:0] lkp_idx;
    logic [IDX_W-1:0] upd_idx;
    ctr_t             ctr_q [DEPTH];
    ctr_t             upd_cur;
    ctr_t             upd_nxt;
    logic [DEPTH-1:0] entry_we;

    bp2_index #(.PC_W(PC_W), .DEPTH(DEPTH), .ALIGN_BITS(ALIGN_BITS)) u_lkp_index (
        .pc(lkp_pc), .idx(lkp_idx));
    bp2_index #(.PC_W(PC_W), .DEPTH(DEPTH), .ALIGN_BITS(ALIGN_BITS)) u_upd_index (
        .pc(upd_pc), .idx(upd_idx));

    // Read the prediction bit and the state to be updated.
    always_comb begin
        lkp_taken = ctr_q[lkp_idx][1];
        upd_cur   = ctr_q[upd_idx];
    end

    bp2_ctr_next u_next (.cur(upd_cur), .taken(upd_taken), .nxt(upd_nxt));

    for (genvar i = 0; i < DEPTH; i++) begin : g_entry
        assign entry_we[i] = upd_en && (upd_idx == IDX_W'(i));
        bp2_entry #(.INIT_STATE(INIT_STATE)) u_entry (
            .clk(clk), .rst_n(rst_n), .we(entry_we[i]), .taken(upd_taken),
            .nxt(upd_nxt), .q(ctr_q[i]));
    end

    a_r8_single_write: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(entry_we));
    a_r9_no_write_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_en |-> entry_we == '0);
endmodule

// File: tb/dir_predictor_bench.sv
module dir_predictor_bench;
    localparam int PC_W = 32;
    localparam int DEPTH = 16;
    localparam int IW = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [PC_W-1:0] lkp_pc = '0;
    logic            lkp_taken;
    logic            upd_en = 1'b0;
    logic [PC_W-1:0] upd_pc = '0;
    logic            upd_taken = 1'b0;

    int n_chk = 0;
    int n_fail = 0;
    logic [1:0] mdl [DEPTH];
    logic [31:0] rng = 32'h1234_5678;

    dir_predictor u_dir_predictor (.clk(clk), .rst_n(rst_n), .lkp_pc(lkp_pc),
        .lkp_taken(lkp_taken), .upd_en(upd_en), .upd_pc(upd_pc), .upd_taken(upd_taken));

    always #2 clk = ~clk;

    function automatic logic [1:0] step(input logic [1:0] s, input logic t);
        if (t) return (s == 2'b00) ? 2'b01 : 2'b11;
        return (s == 2'b11) ? 2'b10 : 2'b00;
    endfunction

    function automatic string from_tag(input logic [1:0] s);
        case (s)
            2'b00: return "R4";
            2'b01: return "R5";
            2'b10: return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic next_rng();
        rng ^= rng << 13; rng ^= rng >> 17; rng ^= rng << 5;
    endtask

    task automatic check(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: lkp_taken=%0b expected %0b", tag, act, exp);
        end
    endtask

    function automatic logic [PC_W-1:0] mkpc(input int idx, input logic [31:0] r);
        return {r[31:IW+2], IW'(idx), r[1:0]};
    endfunction

    task automatic sweep_all(input string tag);
        for (int i = 0; i < DEPTH; i++) begin
            next_rng();
            lkp_pc = mkpc(i, rng);
            #1;
            check(tag, lkp_taken, mdl[i][1]);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0; upd_en = 1'b1; upd_taken = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1; upd_en = 1'b0;
        for (int i = 0; i < DEPTH; i++) mdl[i] = 2'b10;
    endtask

    initial begin
        #800000;
        n_fail++;
        $display("FAIL watchdog: run did not finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int prev_idx = 0;
        string prev_tag = "R9";
        do_reset();
        sweep_all("R1");
        // Directed: 10 taken -> 11, then not-taken -> 10 (still taken), not-taken -> 00.
        @(negedge clk); upd_en = 1; upd_pc = mkpc(3, 32'hFFFF_FFFF); upd_taken = 1;
        lkp_pc = mkpc(3, 32'h0); #1; check("R10", lkp_taken, 1'b1);
        @(negedge clk); upd_taken = 0; #1; check("R6", lkp_taken, 1'b1);
        @(negedge clk); #1; check("R7", lkp_taken, 1'b1);
        @(negedge clk); upd_en = 0; #1; check("R6", lkp_taken, 1'b0);
        mdl[3] = 2'b00;
        sweep_all("R8");
        // Random sweep against the model.
        for (int n = 0; n < 6000; n++) begin
            int ui;
            int li;
            next_rng();
            ui = int'(rng[9:6]);
            upd_en = (rng[12:10] != 3'b000);
            upd_taken = rng[13] ^ rng[20];
            upd_pc = mkpc(ui, {rng[31:16], rng[15:0] ^ 16'hA5A5});
            next_rng();
            li = (rng[1:0] == 2'b00) ? int'(rng[7:4]) : prev_idx;
            lkp_pc = mkpc(li, rng);
            #1;
            if (upd_en && li == ui) check("R10", lkp_taken, mdl[li][1]);
            else if (li == prev_idx) check(prev_tag, lkp_taken, mdl[li][1]);
            else check("R2", lkp_taken, mdl[li][1]);
            @(posedge clk);
            prev_idx = ui;
            prev_tag = upd_en ? from_tag(mdl[ui]) : "R9";
            if (upd_en) mdl[ui] = step(mdl[ui], upd_taken);
            @(negedge clk);
            if (n % 500 == 499) begin
                upd_en = 0;
                sweep_all("R8");
            end
        end
        upd_en = 0;
        sweep_all("R3");
        do_reset();
        sweep_all("R1");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule